// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps a file of NUM_PHYS physical registers, each DW bits wide, and shows sixteen of them at a time through a window that moves in steps of four registers. It holds the window position (`window_base`, counted in four-register groups and wrapping over NUM_PHYS/4 groups) and a live-frame mask (`window_start`) with one bit per group. A register port reads and writes through the current window.

An operation command drives the windowed-call protocol. The operations are frame entry, frame room check, frame return, free rotation, restore of a saved base, and stack-pointer move check. The block decides legality, moves the window and updates the live-frame mask. It reports illegal-instruction, alloca, spill (4/8/12) and fill (4/8/12) exception requests together with the status updates that go with them: set exception mode, old-base value and exception PC. Status bits come in as plain inputs. The spill and fill handlers themselves run elsewhere. Moving the window only changes a pointer. No register contents are copied.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset `window_base` is 0, `window_start` has only bit 0 set and `exc_valid`, `ret_valid`, `excm_set`, `owb_we`, `epc_we` are 0. Window positions wrap modulo NUM_PHYS/4.
- R2: Visible register i (0..15) is physical register (window_base*4 + i) mod NUM_PHYS. `rd_data` shows visible `rd_idx` combinationally, and `wr_en` writes visible `wr_idx` at the clock edge.
- R3: Frame entry (op_code 1) is illegal when `op_sreg` > 3, or when `ps_woe` is not 1, or when `ps_excm` is not 0. It then reports exc_code 1 and leaves the window and the mask unchanged.
- R4: A legal frame entry writes visible register `ps_callinc`*4 + `op_sreg` with a[`op_sreg`] − (`op_imm` << 3). It adds `ps_callinc` to the base and sets the mask bit at the new base.
- R5: Room check (op_code 2) does nothing when `ps_woe`=0 or `ps_excm`=1. It also does nothing when no mask bit is set at base+n for any n from 1 to `op_wcnt`.
- R6: Otherwise room check takes the smallest such n, sets m = base+n and moves the base to m. It outputs the old base on `owb_val` with `owb_we`, raises `excm_set`, and puts `op_pc` on `epc_val` with `epc_we`. The exc_code is 3 if mask bit m+1 is set, else 4 if bit m+2 is set, else 5.
- R7: Frame return (op_code 3) takes n = a0[DW-1:DW-2] and k = the smallest of 1, 2, 3 with the mask bit at base−k set (0 if none). It is illegal (exc_code 1, no state change) if n = 0, if k ≠ 0 and k ≠ n, or if windowing is not enabled. Otherwise it raises `ret_valid` with `ret_pc` = {op_pc[DW-1:DW-2], a0[DW-3:0]}.
- R8: A legal return moves the base to base−n. If the mask bit at the new base is set, it clears the bit at the old base.
- R9: If that bit is clear, the return reports a fill with exc_code 6, 7 or 8 for n = 1, 2 or 3. It updates old base, exception mode and exception PC as in R6, and the mask is unchanged.
- R10: Rotate (op_code 4) adds the signed 4-bit `op_rot` to the base. Restore (op_code 5) loads the base from `ps_owb`.
- R11: Stack-pointer move check (op_code 6) reports exc_code 2 when the mask bits at base−1, base−2 and base−3 are all clear. Otherwise it reports nothing.
- R12: A port write in the same cycle as an operation uses the base in force before the operation. When it hits the same physical register as a frame-entry write, the frame-entry value is kept.
- R13: `exc_valid`, `exc_code`, `ret_valid`, `ret_pc` and the status update outputs are registered. They appear in the cycle after the operation and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 1 entry, 2 room check, 3 return, 4 rotate, 5 restore, 6 stack-pointer move |
| op_sreg | input | 4 | Register operand of frame entry |
| op_imm | input | 12 | Frame size of frame entry, in 8-byte units |
| op_wcnt | input | 2 | Furthest distance scanned by room check |
| op_rot | input | 4 | Signed rotate amount |
| op_pc | input | DW | PC of the operation |
| ps_woe | input | 1 | Windowing enabled |
| ps_excm | input | 1 | Exception mode |
| ps_callinc | input | 2 | Call increment |
| ps_owb | input | GW | Saved old base |
| rd_idx | input | 4 | Visible read index |
| rd_data | output | DW | Read data |
| wr_en | input | 1 | Port write enable |
| wr_idx | input | 4 | Visible write index |
| wr_data | input | DW | Port write data |
| window_base | output | GW | Current base |
| window_start | output | NUM_PHYS/4 | Live-frame mask |
| exc_valid | output | 1 | Exception request |
| exc_code | output | 4 | 1 illegal, 2 alloca, 3/4/5 spill 4/8/12, 6/7/8 fill 4/8/12 |
| excm_set | output | 1 | Set exception mode |
| owb_we | output | 1 | Old-base update strobe |
| owb_val | output | GW | Old-base value |
| epc_we | output | 1 | Exception PC update strobe |
| epc_val | output | DW | Exception PC value |
| ret_valid | output | 1 | Return target valid |
| ret_pc | output | DW | Return target |

## Verification
Two things can happen in one cycle: a port write and an operation that moves the window or writes a register itself. The bench writes through the port during a rotate. It then reads the value back under the new base, at the index that only the pre-operation base would give. It also writes through the port during a frame entry that targets the same physical register, and then expects the frame-entry value to be the one that remains.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ENTRY   = 3'd1,
    OP_WCHECK  = 3'd2,
    OP_RETURN  = 3'd3,
    OP_ROTATE  = 3'd4,
    OP_RESTORE = 3'd5,
    OP_SPMOVE  = 3'd6
  } op_e;

  typedef enum logic [3:0] {
    EXC_NONE    = 4'd0,
    EXC_ILLEGAL = 4'd1,
    EXC_ALLOCA  = 4'd2,
    EXC_SPILL4  = 4'd3,
    EXC_SPILL8  = 4'd4,
    EXC_SPILL12 = 4'd5,
    EXC_FILL4   = 4'd6,
    EXC_FILL8   = 4'd7,
    EXC_FILL12  = 4'd8
  } exc_e;
endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
  parameter int NUM_PHYS = 32
) (
  input  logic [$clog2(NUM_PHYS/4)-1:0] base,
  input  logic [3:0]                    vidx,
  output logic [$clog2(NUM_PHYS)-1:0]   pidx
);
  localparam int PW = $clog2(NUM_PHYS);

  // modulo NUM_PHYS comes from truncation to PW bits
  assign pidx = PW'({base, 2'b00}) + PW'(vidx);
endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int NUM_PHYS = 32,
  parameter int DW       = 32
) (
  input  logic                        clk,
  input  logic                        pwe,
  input  logic [$clog2(NUM_PHYS)-1:0] pwaddr,
  input  logic [DW-1:0]               pwdata,
  input  logic                        owe,
  input  logic [$clog2(NUM_PHYS)-1:0] owaddr,
  input  logic [DW-1:0]               owdata,
  input  logic [$clog2(NUM_PHYS)-1:0] raddr0,
  input  logic [$clog2(NUM_PHYS)-1:0] raddr1,
  input  logic [$clog2(NUM_PHYS)-1:0] raddr2,
  output logic [DW-1:0]               rdata0,
  output logic [DW-1:0]               rdata1,
  output logic [DW-1:0]               rdata2
);
  localparam int PW = $clog2(NUM_PHYS);

  logic [DW-1:0] cells [NUM_PHYS];

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_cell
    logic          hit_op, hit_port;
    logic [DW-1:0] cell_q;
    assign hit_op   = owe && (owaddr == PW'(g));
    assign hit_port = pwe && (pwaddr == PW'(g));
    // operation write takes priority over the port
    always_ff @(posedge clk) begin
      if (hit_op)        cell_q <= owdata;
      else if (hit_port) cell_q <= pwdata;
    end
    assign cells[g] = cell_q;
  end

  assign rdata0 = cells[raddr0];
  assign rdata1 = cells[raddr1];
  assign rdata2 = cells[raddr2];
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
  import regwin_pkg::*;
#(
  parameter int NUM_PHYS = 32,
  parameter int DW       = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          op_valid,
  input  logic [2:0]                    op_code,
  input  logic [3:0]                    op_sreg,
  input  logic [11:0]                   op_imm,
  input  logic [1:0]                    op_wcnt,
  input  logic [3:0]                    op_rot,
  input  logic [DW-1:0]                 op_pc,
  input  logic                          ps_woe,
  input  logic                          ps_excm,
  input  logic [1:0]                    ps_callinc,
  input  logic [$clog2(NUM_PHYS/4)-1:0] ps_owb,
  input  logic [DW-1:0]                 a_s_val,
  input  logic [DW-1:0]                 a0_val,
  output logic                          opw_en,
  output logic [3:0]                    opw_vidx,
  output logic [DW-1:0]                 opw_data,
  output logic [$clog2(NUM_PHYS/4)-1:0] base_q,
  output logic [NUM_PHYS/4-1:0]         start_q,
  output logic                          exc_valid_q,
  output logic [3:0]                    exc_code_q,
  output logic                          excm_set_q,
  output logic                          owb_we_q,
  output logic [$clog2(NUM_PHYS/4)-1:0] owb_q,
  output logic                          epc_we_q,
  output logic [DW-1:0]                 epc_q,
  output logic                          ret_valid_q,
  output logic [DW-1:0]                 ret_pc_q
);
  localparam int NG = NUM_PHYS / 4;
  localparam int GW = $clog2(NG);

  logic [GW-1:0] base_d, owb_d, rot_ext, hit_base, ret_base, entry_base;
  logic [NG-1:0] start_d;
  logic [1:0]    hit_dist, ret_n, ret_k;
  logic          win_ok, exc_v_d, excm_d, owb_we_d, epc_we_d, ret_v_d, state_en;
  exc_e          exc_d;
  logic [DW-1:0] ret_pc_d;

  always_comb begin
    win_ok     = ps_woe && !ps_excm;
    rot_ext    = GW'($signed(op_rot));
    entry_base = base_q + GW'(ps_callinc);
    hit_dist   = 2'd0;
    for (int k = 3; k >= 1; k--) begin
      if ((2'(k) <= op_wcnt) && start_q[base_q + GW'(k)]) hit_dist = 2'(k);
    end
    hit_base = base_q + GW'(hit_dist);
    if (start_q[base_q - GW'(1)])      ret_k = 2'd1;
    else if (start_q[base_q - GW'(2)]) ret_k = 2'd2;
    else if (start_q[base_q - GW'(3)]) ret_k = 2'd3;
    else                               ret_k = 2'd0;
    ret_n    = a0_val[DW-1 -: 2];
    ret_base = base_q - GW'(ret_n);
    ret_pc_d = {op_pc[DW-1 -: 2], a0_val[DW-3:0]};
  end

  always_comb begin
    base_d   = base_q;
    start_d  = start_q;
    exc_d    = EXC_NONE;
    excm_d   = 1'b0;
    owb_we_d = 1'b0;
    owb_d    = base_q;
    epc_we_d = 1'b0;
    ret_v_d  = 1'b0;
    opw_en   = 1'b0;
    opw_vidx = {ps_callinc, op_sreg[1:0]};
    opw_data = a_s_val - (DW'(op_imm) << 3);
    if (op_valid) begin
      unique case (op_e'(op_code))
        OP_ENTRY: begin
          if ((op_sreg > 4'd3) || !win_ok) begin
            exc_d = EXC_ILLEGAL;
          end else begin
            opw_en              = 1'b1;
            base_d              = entry_base;
            start_d[entry_base] = 1'b1;
          end
        end
        OP_WCHECK: begin
          if (win_ok && (hit_dist != 2'd0)) begin
            base_d   = hit_base;
            excm_d   = 1'b1;
            owb_we_d = 1'b1;
            epc_we_d = 1'b1;
            if (start_q[hit_base + GW'(1)])      exc_d = EXC_SPILL4;
            else if (start_q[hit_base + GW'(2)]) exc_d = EXC_SPILL8;
            else                                 exc_d = EXC_SPILL12;
          end
        end
        OP_RETURN: begin
          if ((ret_n == 2'd0) || ((ret_k != 2'd0) && (ret_k != ret_n)) || !win_ok) begin
            exc_d = EXC_ILLEGAL;
          end else begin
            ret_v_d = 1'b1;
            base_d  = ret_base;
            if (start_q[ret_base]) begin
              start_d[base_q] = 1'b0;
            end else begin
              excm_d   = 1'b1;
              owb_we_d = 1'b1;
              epc_we_d = 1'b1;
              unique case (ret_n)
                2'd1:    exc_d = EXC_FILL4;
                2'd2:    exc_d = EXC_FILL8;
                default: exc_d = EXC_FILL12;
              endcase
            end
          end
        end
        OP_ROTATE:  base_d = base_q + rot_ext;
        OP_RESTORE: base_d = ps_owb;
        OP_SPMOVE:  if (ret_k == 2'd0) exc_d = EXC_ALLOCA;
        default: ;
      endcase
    end
    exc_v_d  = (exc_d != EXC_NONE);
    state_en = op_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= NG'(1);
    end else if (state_en) begin
      base_q  <= base_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid_q <= 1'b0;
      exc_code_q  <= EXC_NONE;
      excm_set_q  <= 1'b0;
      owb_we_q    <= 1'b0;
      owb_q       <= '0;
      epc_we_q    <= 1'b0;
      epc_q       <= '0;
      ret_valid_q <= 1'b0;
      ret_pc_q    <= '0;
    end else begin
      exc_valid_q <= exc_v_d;
      exc_code_q  <= exc_d;
      excm_set_q  <= excm_d;
      owb_we_q    <= owb_we_d;
      owb_q       <= owb_d;
      epc_we_q    <= epc_we_d;
      epc_q       <= op_pc;
      ret_valid_q <= ret_v_d;
      ret_pc_q    <= ret_pc_d;
    end
  end

  AST_MASK_NEVER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    start_q != '0); // R8
  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=> base_q == $past(base_q + rot_ext)); // R10
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd5) |=> base_q == $past(ps_owb)); // R10
  AST_ILLEGAL_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_q && exc_code_q == 4'd1) |-> base_q == $past(base_q)); // R3
  AST_SPILL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_q && exc_code_q >= 4'd3) |-> (excm_set_q && owb_we_q && epc_we_q)); // R6
  AST_FILL_WITH_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_q && exc_code_q >= 4'd6) |-> ret_valid_q); // R9
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NUM_PHYS = 32,
  parameter int DW       = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          op_valid,
  input  logic [2:0]                    op_code,
  input  logic [3:0]                    op_sreg,
  input  logic [11:0]                   op_imm,
  input  logic [1:0]                    op_wcnt,
  input  logic [3:0]                    op_rot,
  input  logic [DW-1:0]                 op_pc,
  input  logic                          ps_woe,
  input  logic                          ps_excm,
  input  logic [1:0]                    ps_callinc,
  input  logic [$clog2(NUM_PHYS/4)-1:0] ps_owb,
  input  logic [3:0]                    rd_idx,
  output logic [DW-1:0]                 rd_data,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_idx,
  input  logic [DW-1:0]                 wr_data,
  output logic [$clog2(NUM_PHYS/4)-1:0] window_base,
  output logic [NUM_PHYS/4-1:0]         window_start,
  output logic                          exc_valid,
  output logic [3:0]                    exc_code,
  output logic                          excm_set,
  output logic                          owb_we,
  output logic [$clog2(NUM_PHYS/4)-1:0] owb_val,
  output logic                          epc_we,
  output logic [DW-1:0]                 epc_val,
  output logic                          ret_valid,
  output logic [DW-1:0]                 ret_pc
);
  localparam int PW     = $clog2(NUM_PHYS);
  localparam int NPORTS = 5;

  logic          opw_en;
  logic [3:0]    opw_vidx;
  logic [DW-1:0] opw_data, a_s_val, a0_val;
  logic [3:0]    vidx [NPORTS];
  logic [PW-1:0] pidx [NPORTS];

  assign vidx[0] = rd_idx;
  assign vidx[1] = op_sreg;
  assign vidx[2] = 4'd0;
  assign vidx[3] = wr_idx;
  assign vidx[4] = opw_vidx;

  for (genvar p = 0; p < NPORTS; p++) begin : g_map
    regwin_map #(.NUM_PHYS(NUM_PHYS)) u_map (
      .base (window_base),
      .vidx (vidx[p]),
      .pidx (pidx[p])
    );
  end

  regwin_file #(.NUM_PHYS(NUM_PHYS), .DW(DW)) u_file (
    .clk    (clk),
    .pwe    (wr_en),
    .pwaddr (pidx[3]),
    .pwdata (wr_data),
    .owe    (opw_en),
    .owaddr (pidx[4]),
    .owdata (opw_data),
    .raddr0 (pidx[0]),
    .raddr1 (pidx[1]),
    .raddr2 (pidx[2]),
    .rdata0 (rd_data),
    .rdata1 (a_s_val),
    .rdata2 (a0_val)
  );

  regwin_seq #(.NUM_PHYS(NUM_PHYS), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .op_sreg     (op_sreg),
    .op_imm      (op_imm),
    .op_wcnt     (op_wcnt),
    .op_rot      (op_rot),
    .op_pc       (op_pc),
    .ps_woe      (ps_woe),
    .ps_excm     (ps_excm),
    .ps_callinc  (ps_callinc),
    .ps_owb      (ps_owb),
    .a_s_val     (a_s_val),
    .a0_val      (a0_val),
    .opw_en      (opw_en),
    .opw_vidx    (opw_vidx),
    .opw_data    (opw_data),
    .base_q      (window_base),
    .start_q     (window_start),
    .exc_valid_q (exc_valid),
    .exc_code_q  (exc_code),
    .excm_set_q  (excm_set),
    .owb_we_q    (owb_we),
    .owb_q       (owb_val),
    .epc_we_q    (epc_we),
    .epc_q       (epc_val),
    .ret_valid_q (ret_valid),
    .ret_pc_q    (ret_pc)
  );
endmodule

// File: tb/tb_regwin_ctrl.sv
module tb_regwin_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_PHYS   = 32;
  localparam int DW         = 32;
  localparam int GW         = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid;
  logic [2:0] op_code;
  logic [3:0] op_sreg, op_rot, rd_idx, wr_idx;
  logic [11:0] op_imm;
  logic [1:0] op_wcnt, ps_callinc;
  logic [DW-1:0] op_pc, rd_data, wr_data, epc_val, ret_pc;
  logic ps_woe, ps_excm, wr_en;
  logic [GW-1:0] ps_owb, window_base, owb_val;
  logic [7:0] window_start;
  logic exc_valid, excm_set, owb_we, epc_we, ret_valid;
  logic [3:0] exc_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_ctrl #(.NUM_PHYS(NUM_PHYS), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_sreg(op_sreg), .op_imm(op_imm), .op_wcnt(op_wcnt), .op_rot(op_rot),
    .op_pc(op_pc), .ps_woe(ps_woe), .ps_excm(ps_excm), .ps_callinc(ps_callinc),
    .ps_owb(ps_owb), .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .window_base(window_base),
    .window_start(window_start), .exc_valid(exc_valid), .exc_code(exc_code),
    .excm_set(excm_set), .owb_we(owb_we), .owb_val(owb_val), .epc_we(epc_we),
    .epc_val(epc_val), .ret_valid(ret_valid), .ret_pc(ret_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic port_write(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_vis(input logic [3:0] idx, output logic [31:0] d);
    rd_idx = idx;
    #1;
    d = rd_data;
  endtask

  task automatic do_op(input logic [2:0] code, input logic [3:0] s, input logic [11:0] imm,
                       input logic [1:0] w, input logic [3:0] rot, input logic [31:0] pc,
                       input logic woe, input logic excm, input logic [1:0] cinc,
                       input logic [GW-1:0] owb, input logic pw_en,
                       input logic [3:0] pw_idx, input logic [31:0] pw_data);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_sreg = s; op_imm = imm; op_wcnt = w;
    op_rot = rot; op_pc = pc; ps_woe = woe; ps_excm = excm; ps_callinc = cinc;
    ps_owb = owb; wr_en = pw_en; wr_idx = pw_idx; wr_data = pw_data;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rotate(input logic [3:0] r);
    do_op(3'd4, 0, 0, 0, r, 0, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic restore(input logic [GW-1:0] b);
    do_op(3'd5, 0, 0, 0, 0, 0, 1, 0, 0, b, 0, 0, 0);
  endtask

  task automatic test_reset();
    chk("R1 base", 32'(window_base), 0);
    chk("R1 mask", 32'(window_start), 32'h01);
    chk("R1 exc_valid", 32'(exc_valid), 0);
    chk("R1 ret_valid", 32'(ret_valid), 0);
  endtask

  task automatic test_mapping();
    logic [31:0] d;
    port_write(4'd3, 32'hA0A0_0003);
    rotate(4'd1);
    chk("R10 rotate +1", 32'(window_base), 1);
    port_write(4'd3, 32'hB0B0_0007);
    rotate(4'hF);
    chk("R10 rotate -1", 32'(window_base), 0);
    read_vis(4'd3, d); chk("R2 read vis3 base0", d, 32'hA0A0_0003);
    read_vis(4'd7, d); chk("R2 read vis7 base0", d, 32'hB0B0_0007);
    rotate(4'hF);
    chk("R1 wrap to 7", 32'(window_base), 7);
    read_vis(4'd7, d); chk("R2 wrapped map", d, 32'hA0A0_0003);
    restore(3'd0);
    chk("R10 restore", 32'(window_base), 0);
    // R12: port write during rotate lands at pre-rotate physical 4
    do_op(3'd4, 0, 0, 0, 4'd1, 0, 1, 0, 0, 0, 1, 4'd4, 32'h0000_00C4);
    read_vis(4'd0, d); chk("R12 write uses old base", d, 32'h0000_00C4);
    rotate(4'hF);
  endtask

  task automatic test_entry_illegal();
    do_op(3'd1, 4'd4, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
    chk("R3 sreg>3 code", 32'(exc_code), 1);
    chk("R3 sreg>3 valid", 32'(exc_valid), 1);
    chk("R3 base kept", 32'(window_base), 0);
    do_op(3'd1, 4'd1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3 woe=0", 32'(exc_code), 1);
    do_op(3'd1, 4'd1, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0);
    chk("R3 excm=1", 32'(exc_code), 1);
    chk("R3 mask kept", 32'(window_start), 32'h01);
  endtask

  task automatic test_entry();
    logic [31:0] d;
    port_write(4'd1, 32'd1000);
    // R12: same-cycle port write to the same physical register loses
    do_op(3'd1, 4'd1, 12'd5, 0, 0, 0, 1, 0, 2'd2, 0, 1, 4'd9, 32'h0000_DEAD);
    chk("R4 no exc", 32'(exc_valid), 0);
    chk("R4 base", 32'(window_base), 2);
    chk("R4 mask", 32'(window_start), 32'h05);
    read_vis(4'd1, d); chk("R4 R12 entry value kept", d, 32'd960);
  endtask

  task automatic test_wcheck();
    do_op(3'd2, 0, 0, 2'd3, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 no hit", 32'(exc_valid), 0);
    chk("R5 base kept", 32'(window_base), 2);
    rotate(4'd4);
    do_op(3'd2, 0, 0, 2'd2, 0, 32'h100, 1, 1, 0, 0, 0, 0, 0);
    chk("R5 excm blocks", 32'(exc_valid), 0);
    chk("R5 base kept 6", 32'(window_base), 6);
    do_op(3'd2, 0, 0, 2'd2, 0, 32'h100, 1, 0, 0, 0, 0, 0, 0);
    chk("R6 spill8 code", 32'(exc_code), 4);
    chk("R6 base", 32'(window_base), 0);
    chk("R6 owb", 32'({owb_we, owb_val}), 32'h0E);
    chk("R6 excm", 32'(excm_set), 1);
    chk("R6 epc", epc_we ? epc_val : 32'hFFFF_FFFF, 32'h100);
    do_op(3'd2, 0, 0, 2'd1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 limit w=1", 32'(exc_valid), 0);
    do_op(3'd2, 0, 0, 2'd2, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R6 spill12 code", 32'(exc_code), 5);
    chk("R6 spill12 base", 32'(window_base), 2);
    do_op(3'd1, 4'd0, 0, 0, 0, 0, 1, 0, 2'd1, 0, 0, 0, 0);
    chk("R4 mask second", 32'(window_start), 32'h0D);
    rotate(4'hE);
    do_op(3'd2, 0, 0, 2'd1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R6 spill4 code", 32'(exc_code), 3);
    chk("R6 spill4 owb", 32'(owb_val), 1);
    chk("R6 spill4 base", 32'(window_base), 2);
  endtask

  task automatic test_return();
    rotate(4'd1);
    port_write(4'd0, 32'h4000_0123);
    do_op(3'd3, 0, 0, 0, 0, 32'hC000_0010, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 ret_valid", 32'(ret_valid), 1);
    chk("R7 ret_pc", ret_pc, 32'hC000_0123);
    chk("R8 no exc", 32'(exc_valid), 0);
    chk("R8 base", 32'(window_base), 2);
    chk("R8 mask cleared", 32'(window_start), 32'h05);
    port_write(4'd0, 32'h4000_0000);
    do_op(3'd3, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 k!=n illegal", 32'(exc_code), 1);
    chk("R7 no ret", 32'(ret_valid), 0);
    port_write(4'd0, 32'h0000_0001);
    do_op(3'd3, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 n=0 illegal", 32'(exc_code), 1);
    port_write(4'd0, 32'h8000_0000);
    do_op(3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 disabled illegal", 32'(exc_code), 1);
    chk("R7 base kept", 32'(window_base), 2);
    do_op(3'd3, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R8 n=2 base", 32'(window_base), 0);
    chk("R8 n=2 mask", 32'(window_start), 32'h01);
    port_write(4'd0, 32'hC000_0055);
    do_op(3'd3, 0, 0, 0, 0, 32'h4000_0000, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 fill12 code", 32'(exc_code), 8);
    chk("R9 ret_pc", ret_pc, 32'h4000_0055);
    chk("R9 base", 32'(window_base), 5);
    chk("R9 owb", 32'({owb_we, owb_val}), 32'h08);
    chk("R9 epc", epc_we ? epc_val : 32'hFFFF_FFFF, 32'h4000_0000);
    chk("R9 mask kept", 32'(window_start), 32'h01);
    restore(3'd4);
    port_write(4'd0, 32'h4000_0000);
    do_op(3'd3, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 fill4 code", 32'(exc_code), 6);
    chk("R9 fill4 base", 32'(window_base), 3);
  endtask

  task automatic test_spmove();
    do_op(3'd6, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R11 live frame no exc", 32'(exc_valid), 0);
    restore(3'd5);
    do_op(3'd6, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R11 alloca code", 32'(exc_code), 2);
    chk("R11 alloca valid", 32'(exc_valid), 1);
    @(negedge clk);
    chk("R13 one-cycle pulse", 32'(exc_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; op_valid = 0; op_code = 0; op_sreg = 0; op_imm = 0; op_wcnt = 0;
    op_rot = 0; op_pc = 0; ps_woe = 0; ps_excm = 0; ps_callinc = 0; ps_owb = 0;
    rd_idx = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_mapping();
    test_entry_illegal();
    test_entry();
    test_wcheck();
    test_return();
    test_spmove();
    summary();
  end
endmodule